// File: doc/BRIEF.md
# LCD Direct/Duplex Drive Waveform Generator

This block turns eight bytes of segment memory and two display-control bits into frame-timed drive codes for one or two LCD backplanes and a row of segment electrodes. Each output is a two-bit level code that a separate analog stage turns into low, mid-rail or high voltage, or into a released (high-impedance) pin. A clock-enable `tick` stands in for the display oscillator. A parameterised divider turns those ticks into phase steps. Four phases make one frame. The generator is sized so that a frame lands near 90 Hz, within a 65 to 120 Hz window.

In direct drive a single backplane swings full scale, and one of two memory banks (the even or the odd bytes) is shown. In duplex drive two backplanes take turns on a three-level waveform, and each segment carries one bit for each backplane. In the slave role the backplane pins are released and the frame is restarted from an observed external backplane edge. A modulation-disable input freezes the backplane low, so the segment pins carry the raw memory bits as a static output port.

Top module: `lcd_wave_gen`

## Requirements
- R1: While reset is asserted, every segment code and both backplane codes are low (00). With `slaveMode` = 1 the two backplane codes are high-impedance (11) instead.
- R2: Level codes are 00 = low, 01 = mid, 10 = high and 11 = high-impedance. A segment code is never 11.
- R3: Every `TICK_DIV` ticks make one phase step (phase 0,1,2,3 then 0 again). All output codes change together, and only in the cycle after a phase step or a slave sync. Changes to the memory, the mode or modulation-disable between steps leave the outputs unchanged.
- R4: The segment memory is byte-packed, with register r at bits [8r+7:8r]. Segment index s (0-based, code at `segCode[2s+1:2s]`) uses bit s%8 of register 2*(s/8) (even) and bit s%8 of register 2*(s/8)+1 (odd).
- R5: Direct mode (`modeDuplex` = 0): backplane 1 is high in phases 0 and 1 and low in phases 2 and 3. Backplane 2 is low. A segment whose displayed bit is 1 takes the opposite of backplane 1 (high becomes low, low becomes high). A segment whose displayed bit is 0 takes the same level as backplane 1.
- R6: In direct mode `bankSel` = 0 displays the even registers and `bankSel` = 1 the odd ones. Both `bankSel` and `modeDuplex` are taken only at the step into phase 0 (or at a slave sync), so a change takes effect at the next frame boundary.
- R7: Duplex mode: backplane 1 is high in phase 0, low in phase 1 and mid in phases 2 and 3. Backplane 2 is mid in phases 0 and 1, high in phase 2 and low in phase 3. The two backplanes are never high together.
- R8: In duplex mode, phases 0 and 1 use the even bit and phases 2 and 3 use the odd bit. A segment whose bit is 1 drives the opposite of the active backplane, and a segment whose bit is 0 drives the same level. `bankSel` has no effect.
- R9: While `slaveMode` = 1 both backplane codes are 11. While `slaveMode` = 0 neither is 11.
- R10: In slave mode a rising edge on `extBp` (sampled on the clock) restarts the frame: the outputs move to their phase-0 values in the next cycle, and the divider begins a fresh count of `TICK_DIV` ticks.
- R11: With `modDisable` = 1 at a phase step, both backplanes are driven low. Each segment is driven high if its displayed direct-mode bit (chosen by the frame's bank) is 1 and low if it is 0, in every phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oscillator clock-enable pulse |
| segRegs | input | 2*SEG_COUNT | Eight segment bytes, register r at [8r+7:8r] |
| modeDuplex | input | 1 | 0 = direct drive, 1 = duplex drive |
| bankSel | input | 1 | Direct-mode bank: 0 even registers, 1 odd registers |
| slaveMode | input | 1 | Backplanes released, frame synced to `extBp` |
| extBp | input | 1 | Observed external backplane for slave sync |
| modDisable | input | 1 | Static output: backplanes low, raw bits on segments |
| bp1Code | output | 2 | Backplane 1 level code |
| bp2Code | output | 2 | Backplane 2 level code |
| segCode | output | 2*SEG_COUNT | Segment level codes, segment s at [2s+1:2s] |

## Verification
The bench builds the block with `TICK_DIV` = 3 and the default 32 segments. A phase then lasts three ticks, so hundreds of full frames fit in a short run. That brings within reach bank and mode changes placed at every point inside a frame, slave syncs landing in each phase, and ticks that come between phase steps. Random memory contents across all 32 segments cover the even/odd register mapping in both drive modes.

// File: rtl/lwg_pkg.sv
package lwg_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_HIZ  = 2'b11
  } level_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;    // capture new output codes this cycle
    logic [1:0] phase;   // phase the new codes belong to
    logic       duplex;  // frame drive mode
    logic       bank;    // frame bank (direct mode)
  } wave_strobe_t;

  function automatic level_e invLevel(input level_e lvl);
    case (lvl)
      LVL_HIGH: return LVL_LOW;
      LVL_LOW:  return LVL_HIGH;
      default:  return lvl;
    endcase
  endfunction

endpackage

// File: rtl/lwg_ctrl.sv
module lwg_ctrl
  import lwg_pkg::*;
#(
  parameter int TICK_DIV = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         slaveMode,
  input  logic         extBp,
  input  logic         modeDuplex,
  input  logic         bankSel,
  output wave_strobe_t strobe
);

  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] divCnt;
  logic [1:0]       phaseQ;
  logic             modeQ;
  logic             bankQ;
  logic             extPrev;

  logic       divWrap;
  logic       syncHit;
  logic       stepHit;
  logic       loadHit;
  logic       frameStart;
  logic [1:0] nextPhase;

  always_comb begin
    divWrap    = (divCnt == DIV_LAST);
    syncHit    = slaveMode && extBp && !extPrev;
    stepHit    = tick && divWrap;
    loadHit    = syncHit || stepHit;
    nextPhase  = syncHit ? 2'd0 : phaseQ + 2'd1;
    frameStart = loadHit && (nextPhase == 2'd0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt  <= '0;
      phaseQ  <= 2'd0;
      modeQ   <= 1'b0;
      bankQ   <= 1'b0;
      extPrev <= 1'b0;
    end else begin
      extPrev <= extBp;
      if (syncHit) begin
        divCnt <= '0;
      end else if (tick) begin
        divCnt <= divWrap ? '0 : divCnt + 1'b1;
      end
      if (loadHit) phaseQ <= nextPhase;
      if (frameStart) begin
        modeQ <= modeDuplex;
        bankQ <= bankSel;
      end
    end
  end

  always_comb begin
    strobe.load   = loadHit;
    strobe.phase  = nextPhase;
    strobe.duplex = frameStart ? modeDuplex : modeQ;
    strobe.bank   = frameStart ? bankSel : bankQ;
  end

endmodule

// File: rtl/lwg_datapath.sv
module lwg_datapath
  import lwg_pkg::*;
#(
  parameter int SEG_COUNT = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  wave_strobe_t           strobe,
  input  logic [2*SEG_COUNT-1:0] segRegs,
  input  logic                   modDisable,
  input  logic                   slaveMode,
  output logic [1:0]             bp1Code,
  output logic [1:0]             bp2Code,
  output logic [2*SEG_COUNT-1:0] segCode
);

  localparam int CODE_W = 2 * SEG_COUNT;

  level_e            bp1Q, bp2Q;
  level_e            bp1Nxt, bp2Nxt;
  logic [CODE_W-1:0] segQ;
  logic [CODE_W-1:0] segNxt;

  function automatic level_e pickSeg(input logic evenB, input logic oddB,
                                     input wave_strobe_t st, input logic modDis);
    logic   dirBit;
    level_e active;
    level_e plane;
    dirBit = st.bank ? oddB : evenB;
    active = st.phase[0] ? LVL_LOW : LVL_HIGH;
    plane  = st.phase[1] ? LVL_LOW : LVL_HIGH;
    if (modDis)
      return dirBit ? LVL_HIGH : LVL_LOW;
    else if (!st.duplex)
      return dirBit ? invLevel(plane) : plane;
    else
      return (st.phase[1] ? oddB : evenB) ? invLevel(active) : active;
  endfunction

  // backplane levels for the phase being loaded
  always_comb begin
    if (modDisable) begin
      bp1Nxt = LVL_LOW;
      bp2Nxt = LVL_LOW;
    end else if (!strobe.duplex) begin
      bp1Nxt = strobe.phase[1] ? LVL_LOW : LVL_HIGH;
      bp2Nxt = LVL_LOW;
    end else begin
      case (strobe.phase)
        2'd0:    begin bp1Nxt = LVL_HIGH; bp2Nxt = LVL_MID;  end
        2'd1:    begin bp1Nxt = LVL_LOW;  bp2Nxt = LVL_MID;  end
        2'd2:    begin bp1Nxt = LVL_MID;  bp2Nxt = LVL_HIGH; end
        default: begin bp1Nxt = LVL_MID;  bp2Nxt = LVL_LOW;  end
      endcase
    end
  end

  // segment s: pair k = s/8, bit b = s%8
  for (genvar g = 0; g < SEG_COUNT; g++) begin : g_seg
    localparam int PAIR = g / 8;
    localparam int BITI = g % 8;
    assign segNxt[2*g +: 2] = pickSeg(segRegs[16*PAIR + BITI],
                                      segRegs[16*PAIR + 8 + BITI],
                                      strobe, modDisable);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp1Q <= LVL_LOW;
      bp2Q <= LVL_LOW;
      segQ <= '0;
    end else if (strobe.load) begin
      bp1Q <= bp1Nxt;
      bp2Q <= bp2Nxt;
      segQ <= segNxt;
    end
  end

  assign bp1Code = slaveMode ? LVL_HIZ : bp1Q;
  assign bp2Code = slaveMode ? LVL_HIZ : bp2Q;
  assign segCode = segQ;

endmodule

// File: rtl/lcd_wave_gen.sv
module lcd_wave_gen
  import lwg_pkg::*;
#(
  parameter int SEG_COUNT = 32,
  parameter int TICK_DIV  = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic [2*SEG_COUNT-1:0] segRegs,
  input  logic                   modeDuplex,
  input  logic                   bankSel,
  input  logic                   slaveMode,
  input  logic                   extBp,
  input  logic                   modDisable,
  output logic [1:0]             bp1Code,
  output logic [1:0]             bp2Code,
  output logic [2*SEG_COUNT-1:0] segCode
);

  wave_strobe_t strobe;

  lwg_ctrl #(.TICK_DIV(TICK_DIV)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .slaveMode  (slaveMode),
    .extBp      (extBp),
    .modeDuplex (modeDuplex),
    .bankSel    (bankSel),
    .strobe     (strobe)
  );

  lwg_datapath #(.SEG_COUNT(SEG_COUNT)) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .segRegs    (segRegs),
    .modDisable (modDisable),
    .slaveMode  (slaveMode),
    .bp1Code    (bp1Code),
    .bp2Code    (bp2Code),
    .segCode    (segCode)
  );

endmodule

// File: rtl/lwg_checker.sv
module lwg_checker #(
  parameter int SEG_COUNT = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tick,
  input logic                   slaveMode,
  input logic                   extBp,
  input logic [1:0]             bp1Code,
  input logic [1:0]             bp2Code,
  input logic [2*SEG_COUNT-1:0] segCode
);

  logic extPrevC;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) extPrevC <= 1'b0;
    else        extPrevC <= extBp;
  end

  // outputs only move after a tick or a slave sync edge
  assert_seg_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(slaveMode && extBp && !extPrevC)) |=> $stable(segCode));

  // backplanes are never both at the high level
  assert_bp_not_both_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bp1Code == 2'b10 && bp2Code == 2'b10));

  // a driving (master) generator never releases its backplanes
  assert_master_bp_driven_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !slaveMode |-> (bp1Code != 2'b11 && bp2Code != 2'b11));

  for (genvar g = 0; g < SEG_COUNT; g++) begin : g_chk
    assert_seg_no_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
      segCode[2*g +: 2] != 2'b11);
  end

endmodule

bind lcd_wave_gen lwg_checker #(.SEG_COUNT(SEG_COUNT)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .slaveMode (slaveMode),
  .extBp     (extBp),
  .bp1Code   (bp1Code),
  .bp2Code   (bp2Code),
  .segCode   (segCode)
);

// File: tb/lcd_wave_gen_tb_top.sv
`timescale 1ns/1ps
module lcd_wave_gen_tb_top;

  localparam int SEGS = 32;
  localparam int DIV  = 3;
  localparam int CW   = 2 * SEGS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [CW-1:0] segRegs = '0;
  logic          modeDuplex = 1'b0;
  logic          bankSel = 1'b0;
  logic          slaveMode = 1'b0;
  logic          extBp = 1'b0;
  logic          modDisable = 1'b0;
  logic [1:0]    bp1Code, bp2Code;
  logic [CW-1:0] segCode;

  always #5 clk = ~clk;

  lcd_wave_gen #(.SEG_COUNT(SEGS), .TICK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .segRegs(segRegs),
    .modeDuplex(modeDuplex), .bankSel(bankSel), .slaveMode(slaveMode),
    .extBp(extBp), .modDisable(modDisable),
    .bp1Code(bp1Code), .bp2Code(bp2Code), .segCode(segCode)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model state
  int            mPhase = 0;
  int            mCnt   = 0;
  bit            mDup   = 1'b0;
  bit            mBank  = 1'b0;
  logic [1:0]    eBp1 = 2'b00, eBp2 = 2'b00;
  logic [CW-1:0] eSeg = '0;

  function automatic logic [1:0] flip(input logic [1:0] l);
    if (l == 2'b10) return 2'b00;
    if (l == 2'b00) return 2'b10;
    return l;
  endfunction

  function automatic logic [1:0] refBp1(input int ph, input bit dup, input bit md);
    if (md) return 2'b00;
    if (!dup) return (ph < 2) ? 2'b10 : 2'b00;
    case (ph)
      0: return 2'b10;
      1: return 2'b00;
      default: return 2'b01;
    endcase
  endfunction

  function automatic logic [1:0] refBp2(input int ph, input bit dup, input bit md);
    if (md || !dup) return 2'b00;
    case (ph)
      2: return 2'b10;
      3: return 2'b00;
      default: return 2'b01;
    endcase
  endfunction

  function automatic logic [1:0] refSeg(input int s, input logic [CW-1:0] r,
                                        input int ph, input bit dup, input bit bk,
                                        input bit md);
    logic e, o, b;
    e = r[16*(s/8) + s%8];
    o = r[16*(s/8) + 8 + s%8];
    b = bk ? o : e;
    if (md) return b ? 2'b10 : 2'b00;
    if (!dup) return b ? flip(refBp1(ph, 1'b0, 1'b0)) : refBp1(ph, 1'b0, 1'b0);
    if (ph < 2) return e ? flip(refBp1(ph, 1'b1, 1'b0)) : refBp1(ph, 1'b1, 1'b0);
    return o ? flip(refBp2(ph, 1'b1, 1'b0)) : refBp2(ph, 1'b1, 1'b0);
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    check(tag, "bp1", CW'(bp1Code), CW'(slaveMode ? 2'b11 : eBp1));
    check(tag, "bp2", CW'(bp2Code), CW'(slaveMode ? 2'b11 : eBp2));
    check(tag, "seg", segCode, eSeg);
  endtask

  task automatic modelLoad();
    eBp1 = refBp1(mPhase, mDup, modDisable);
    eBp2 = refBp2(mPhase, mDup, modDisable);
    for (int s = 0; s < SEGS; s++)
      eSeg[2*s +: 2] = refSeg(s, segRegs, mPhase, mDup, mBank, modDisable);
  endtask

  task automatic doTick(input string tag);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    if (mCnt == DIV - 1) begin
      mCnt = 0;
      mPhase = (mPhase + 1) % 4;
      if (mPhase == 0) begin
        mDup  = modeDuplex;
        mBank = bankSel;
      end
      modelLoad();
    end else begin
      mCnt++;
    end
    checkAll(tag);
  endtask

  task automatic doSync(input string tag);
    @(negedge clk) extBp = 1'b1;
    @(negedge clk) extBp = 1'b0;
    mCnt = 0;
    mPhase = 0;
    mDup  = modeDuplex;
    mBank = bankSel;
    modelLoad();
    checkAll(tag);
  endtask

  task automatic idle(input int n, input string tag);
    repeat (n) @(negedge clk);
    checkAll(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0001));
    // R1: reset state, master then slave role
    repeat (3) @(negedge clk);
    segRegs = {$urandom, $urandom};
    @(negedge clk);
    checkAll("R1");
    slaveMode = 1'b1;
    @(negedge clk);
    checkAll("R1");
    slaveMode = 1'b0;
    segRegs = '0;
    @(negedge clk) rst_n = 1'b1;

    // R4: single bit in register 2, bit 3 -> segment 11
    segRegs = '0;
    segRegs[2*8 + 3] = 1'b1;
    for (int i = 0; i < DIV; i++) doTick("R4");
    check("R4", "seg11 on in phase1", CW'(segCode[23:22]), CW'(2'b00));
    check("R4", "seg10 off in phase1", CW'(segCode[21:20]), CW'(2'b10));

    // R3: memory change without ticks leaves outputs alone
    segRegs = {$urandom, $urandom};
    idle(5, "R3");
    modDisable = 1'b1;
    idle(2, "R3");
    modDisable = 1'b0;
    for (int i = 0; i < DIV - 1; i++) doTick("R3");

    // R5 / R6: direct mode, random data, bank changes anywhere in frame
    for (int i = 0; i < 120; i++) begin
      if ($urandom % 3 == 0) segRegs = {$urandom, $urandom};
      if ($urandom % 5 == 0) bankSel = ~bankSel;
      doTick((i % 2 == 0) ? "R5" : "R6");
      if ($urandom % 7 == 0) idle($urandom % 4 + 1, "R3");
    end

    // R6: mode change mid-frame waits for the boundary
    while (!(mPhase == 1 && mCnt == 0)) doTick("R6");
    modeDuplex = 1'b1;
    for (int i = 0; i < 3 * DIV; i++) doTick("R6");

    // R7 / R8: duplex mode, bank toggling must not matter
    for (int i = 0; i < 160; i++) begin
      if ($urandom % 2 == 0) segRegs = {$urandom, $urandom};
      if ($urandom % 4 == 0) bankSel = ~bankSel;
      doTick((i % 2 == 0) ? "R7" : "R8");
    end

    // R11: static output port
    modDisable = 1'b1;
    for (int i = 0; i < 40; i++) begin
      if ($urandom % 3 == 0) segRegs = {$urandom, $urandom};
      if ($urandom % 6 == 0) bankSel = ~bankSel;
      doTick("R11");
    end
    modDisable = 1'b0;
    modeDuplex = 1'b0;

    // R9 / R10: slave role and frame sync
    slaveMode = 1'b1;
    idle(1, "R9");
    for (int i = 0; i < 10; i++) doTick("R9");
    for (int j = 0; j < 12; j++) begin
      segRegs = {$urandom, $urandom};
      if (j == 6) modeDuplex = 1'b1;
      doSync("R10");
      for (int i = 0; i < int'($urandom % 10); i++) doTick("R10");
    end
    slaveMode = 1'b0;
    idle(1, "R9");

    // R2: no segment code is ever the released level
    for (int i = 0; i < 24; i++) begin
      segRegs = {$urandom, $urandom};
      modeDuplex = $urandom % 2;
      doTick("R2");
      for (int s = 0; s < SEGS; s++)
        if (segCode[2*s +: 2] == 2'b11) check("R2", "seg hiz", CW'(s), CW'(-1));
    end
    check("R2", "no hiz in final segments", CW'(segCode & (segCode >> 1) & {SEGS{2'b01}}), '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule